// File: doc/BRIEF.md
# Internal Data Space Decoder with Core RAM and Stack

This block serves the internal data accesses of an 8-bit controller core. Each cycle it takes one operation (byte, bit, working-register or stack) with an 8-bit address and an addressing-mode flag. It steers the operation to a 256-byte core RAM it holds itself, or to an external special-function-register (SFR) request/response bus. The upper half of the address space depends on the mode. A direct access there reaches the SFR bus. An indirect access there reaches the upper half of core RAM. The lower half is RAM in both modes.

Working registers R0..R7 sit in four banks at the bottom of RAM, picked by a bank-select input. A bit-addressable window of sixteen bytes starts at 0x20. A stack pointer register drives push and pop. The stack always takes the indirect path, so it can use all 256 bytes. Every read, whether from RAM or SFR, returns its data one cycle after the request.

Top module: `idata_decoder`

## Requirements
- R1: After reset `sp_o` is 0x07, `rvalid_o` is 0 and neither `sfr_re_o` nor `sfr_we_o` is asserted. Operation codes on `op_i` are: 0 none, 1 byte read, 2 byte write, 3 bit read, 4 bit write, 5 register read, 6 register write, 7 push, 8 pop.
- R2: A byte read or write at 0x00..0x7F uses core RAM in either mode. A read raises `rvalid_o` in the next cycle, with the byte on `rdata_o`.
- R3: A direct byte access at 0x80..0xFF goes to the SFR bus with `sfr_addr_o` equal to the address. A write drives `sfr_we_o`, `sfr_wdata_o` and `sfr_wmask_o`=0xFF. A read drives `sfr_re_o`, and in the next cycle `rdata_o` carries `sfr_rdata_i`. RAM is not touched.
- R4: An indirect byte access at 0x80..0xFF uses the upper half of core RAM and asserts no SFR strobe.
- R5: A register access to Rn (`reg_idx_i`=n) uses RAM address {`bank_sel_i`, n}, which is bank*8+n.
- R6: A bit address b below 0x80 selects bit b&7 of RAM byte 0x20+(b>>3). A bit write changes only that bit, in a single cycle. A bit read returns the bit on `bit_rdata_o` one cycle later.
- R7: A bit address b at 0x80 or above goes to the SFR bus at address b&0xF8. A bit write drives `sfr_wmask_o` with only bit b&7 set, and `sfr_wdata_o` with the bit value copied into every position. A bit read returns `sfr_rdata_i[b&7]` on `bit_rdata_o` one cycle later.
- R8: A push first increments `sp_o`, then writes `wdata_i` at the new pointer. 0xFF increments to 0x00.
- R9: A pop returns the byte at `sp_o` one cycle later and decrements the pointer. 0x00 decrements to 0xFF.
- R10: `sp_o` changes only on push and pop. Codes 0 and 9..15 start no read, no write and no SFR strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| addr_i | input | 8 | Byte address or bit address |
| indirect_i | input | 1 | 1 = indirect addressing, 0 = direct |
| reg_idx_i | input | 3 | Working register number |
| bank_sel_i | input | 2 | Register bank select |
| wdata_i | input | 8 | Write data for byte, register and push |
| bit_wdata_i | input | 1 | Write value for bit operations |
| rdata_o | output | 8 | Read data, valid with rvalid_o |
| bit_rdata_o | output | 1 | Bit read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response valid, one cycle after request |
| sp_o | output | 8 | Stack pointer |
| sfr_addr_o | output | 8 | SFR bus address |
| sfr_wdata_o | output | 8 | SFR bus write data |
| sfr_wmask_o | output | 8 | SFR bus per-bit write enable |
| sfr_we_o | output | 1 | SFR bus write strobe |
| sfr_re_o | output | 1 | SFR bus read strobe |
| sfr_rdata_i | input | 8 | SFR read data, one cycle after sfr_re_o |

## Verification
The bench uses the default parameters: 8-bit addresses and data, four register banks, bit window at 0x20, pointer reset 0x07. At this size the whole RAM can be filled and read back through the indirect path, and every bank can be reached. The stack pointer can also be walked from its reset value through the 0xFF to 0x00 wrap and back, all within a few hundred cycles. This makes both wraps and the full-range stack directly observable.

// File: rtl/idata_pkg.sv
package idata_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_RD   = 4'd1,
    OP_WR   = 4'd2,
    OP_BRD  = 4'd3,
    OP_BWR  = 4'd4,
    OP_RRD  = 4'd5,
    OP_RWR  = 4'd6,
    OP_PUSH = 4'd7,
    OP_POP  = 4'd8
  } op_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic bit_op;
    logic to_sfr;
    logic push;
    logic pop;
  } acc_t;
endpackage

// File: rtl/idata_addr_map.sv
module idata_addr_map
  import idata_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 4,
  parameter int REG_W     = 3,
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
  input  logic [3:0]                  op_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        indirect_i,
  input  logic [REG_W-1:0]            reg_idx_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_sel_i,
  input  logic [ADDR_W-1:0]           sp_i,
  input  logic [ADDR_W-1:0]           sp_inc_i,
  output acc_t                        acc_o,
  output logic [ADDR_W-1:0]           ram_addr_o,
  output logic [ADDR_W-1:0]           sfr_addr_o,
  output logic [$clog2(DATA_W)-1:0]   bit_idx_o
);
  localparam int BIT_IDX_W = $clog2(DATA_W);
  localparam int BANK_W    = $clog2(NUM_BANKS);

  logic                 upper;
  logic [ADDR_W-1:0]    bit_byte;
  logic [ADDR_W-1:0]    reg_addr;
  logic [ADDR_W-1:0]    bit_sfr;

  assign upper    = addr_i[ADDR_W-1];
  assign bit_byte = BIT_BASE + ADDR_W'(addr_i[ADDR_W-2:BIT_IDX_W]);
  assign reg_addr = ADDR_W'({bank_sel_i, reg_idx_i});
  assign bit_sfr  = {addr_i[ADDR_W-1:BIT_IDX_W], {BIT_IDX_W{1'b0}}};
  assign bit_idx_o = addr_i[BIT_IDX_W-1:0];

  always_comb begin
    acc_o      = '0;
    ram_addr_o = addr_i;
    sfr_addr_o = addr_i;
    unique case (op_e'(op_i))
      OP_RD, OP_WR: begin
        acc_o.rd     = (op_e'(op_i) == OP_RD);
        acc_o.wr     = (op_e'(op_i) == OP_WR);
        acc_o.to_sfr = upper && !indirect_i;
      end
      OP_BRD, OP_BWR: begin
        acc_o.rd     = (op_e'(op_i) == OP_BRD);
        acc_o.wr     = (op_e'(op_i) == OP_BWR);
        acc_o.bit_op = 1'b1;
        acc_o.to_sfr = upper;
        ram_addr_o   = bit_byte;
        sfr_addr_o   = bit_sfr;
      end
      OP_RRD, OP_RWR: begin
        acc_o.rd   = (op_e'(op_i) == OP_RRD);
        acc_o.wr   = (op_e'(op_i) == OP_RWR);
        ram_addr_o = reg_addr;
      end
      OP_PUSH: begin
        acc_o.wr   = 1'b1;
        acc_o.push = 1'b1;
        ram_addr_o = sp_inc_i;
      end
      OP_POP: begin
        acc_o.rd   = 1'b1;
        acc_o.pop  = 1'b1;
        ram_addr_o = sp_i;
      end
      default: acc_o = '0;
    endcase
  end

  logic unused_bank;
  assign unused_bank = ^BANK_W;
endmodule

// File: rtl/idata_stack_ptr.sv
module idata_stack_ptr #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SP_RST = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] sp_inc_o
);
  logic [ADDR_W-1:0] sp_q;

  assign sp_inc_o = sp_q + ADDR_W'(1);
  assign sp_o     = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_q <= SP_RST;
    else if (push_i)  sp_q <= sp_inc_o;
    else if (pop_i)   sp_q <= sp_q - ADDR_W'(1);
  end
endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      re_i,
  input  logic                      we_i,
  input  logic                      bit_we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [$clog2(DATA_W)-1:0] bit_idx_i,
  input  logic                      bit_val_i,
  output logic [DATA_W-1:0]         rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // bit write is a single-cycle read-modify-write of the array word
  always_ff @(posedge clk_i) begin
    if (we_i)          mem[addr_i]            <= wdata_i;
    else if (bit_we_i) mem[addr_i][bit_idx_i] <= bit_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/idata_decoder.sv
module idata_decoder
  import idata_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 4,
  parameter int REG_W     = 3,
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] SP_RST   = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              indirect_i,
  input  logic [REG_W-1:0]  reg_idx_i,
  input  logic [1:0]        bank_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bit_wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bit_rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] sfr_addr_o,
  output logic [DATA_W-1:0] sfr_wdata_o,
  output logic [DATA_W-1:0] sfr_wmask_o,
  output logic              sfr_we_o,
  output logic              sfr_re_o,
  input  logic [DATA_W-1:0] sfr_rdata_i
);
  localparam int BIT_IDX_W = $clog2(DATA_W);

  acc_t                 acc;
  logic [ADDR_W-1:0]    ram_addr;
  logic [ADDR_W-1:0]    map_sfr_addr;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic [ADDR_W-1:0]    sp, sp_inc;
  logic [DATA_W-1:0]    ram_rdata;
  logic                 ram_side;

  idata_addr_map #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS),
    .REG_W(REG_W), .BIT_BASE(BIT_BASE)
  ) u_map (
    .op_i(op_i), .addr_i(addr_i), .indirect_i(indirect_i),
    .reg_idx_i(reg_idx_i), .bank_sel_i(bank_sel_i),
    .sp_i(sp), .sp_inc_i(sp_inc),
    .acc_o(acc), .ram_addr_o(ram_addr), .sfr_addr_o(map_sfr_addr),
    .bit_idx_o(bit_idx)
  );

  idata_stack_ptr #(.ADDR_W(ADDR_W), .SP_RST(SP_RST)) u_sp (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(acc.push), .pop_i(acc.pop),
    .sp_o(sp), .sp_inc_o(sp_inc)
  );

  assign ram_side = !acc.to_sfr;

  idata_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .re_i(acc.rd && ram_side),
    .we_i(acc.wr && ram_side && !acc.bit_op),
    .bit_we_i(acc.wr && ram_side && acc.bit_op),
    .addr_i(ram_addr), .wdata_i(wdata_i),
    .bit_idx_i(bit_idx), .bit_val_i(bit_wdata_i),
    .rdata_o(ram_rdata)
  );

  // SFR request side
  logic [DATA_W-1:0] bit_mask;
  always_comb begin
    bit_mask          = '0;
    bit_mask[bit_idx] = 1'b1;
  end

  assign sfr_addr_o  = map_sfr_addr;
  assign sfr_re_o    = acc.rd && acc.to_sfr;
  assign sfr_we_o    = acc.wr && acc.to_sfr;
  assign sfr_wmask_o = acc.bit_op ? bit_mask : {DATA_W{1'b1}};
  assign sfr_wdata_o = acc.bit_op ? {DATA_W{bit_wdata_i}} : wdata_i;

  // response tracking, one cycle behind the request
  logic                 rsp_valid_q, rsp_sfr_q;
  logic [BIT_IDX_W-1:0] rsp_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_sfr_q   <= 1'b0;
      rsp_bit_q   <= '0;
    end else begin
      rsp_valid_q <= acc.rd;
      if (acc.rd) begin
        rsp_sfr_q <= acc.to_sfr;
        rsp_bit_q <= bit_idx;
      end
    end
  end

  assign rvalid_o    = rsp_valid_q;
  assign rdata_o     = rsp_sfr_q ? sfr_rdata_i : ram_rdata;
  assign bit_rdata_o = rdata_o[rsp_bit_q];
  assign sp_o        = sp;
endmodule

// File: rtl/idata_decoder_chk.sv
module idata_decoder_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        op_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              indirect_i,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic [ADDR_W-1:0] sfr_addr_o,
  input logic [DATA_W-1:0] sfr_wmask_o,
  input logic              sfr_we_o,
  input logic              sfr_re_o
);
  logic is_read, byte_op, stack_op;
  assign is_read  = (op_i == 4'd1) || (op_i == 4'd3) || (op_i == 4'd5) || (op_i == 4'd8);
  assign byte_op  = (op_i == 4'd1) || (op_i == 4'd2);
  assign stack_op = (op_i == 4'd7) || (op_i == 4'd8);

  assert_strobe_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sfr_re_o && sfr_we_o));

  assert_read_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_read |=> rvalid_o);

  assert_direct_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_op && !indirect_i && addr_i[ADDR_W-1]) |->
      ((sfr_re_o || sfr_we_o) && sfr_addr_o == addr_i));

  assert_indirect_no_sfr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_op && indirect_i) |-> !(sfr_re_o || sfr_we_o));

  assert_bit_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd4 && addr_i[ADDR_W-1]) |-> ($countones(sfr_wmask_o) == 1 && sfr_we_o));

  assert_push_inc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd7) |=> sp_o == $past(sp_o) + ADDR_W'(1));

  assert_pop_dec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd8) |=> sp_o == $past(sp_o) - ADDR_W'(1));

  assert_sp_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stack_op |=> $stable(sp_o));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0 || op_i > 4'd8) |=> !rvalid_o);
endmodule

bind idata_decoder idata_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .addr_i(addr_i),
  .indirect_i(indirect_i), .rvalid_o(rvalid_o), .sp_o(sp_o),
  .sfr_addr_o(sfr_addr_o), .sfr_wmask_o(sfr_wmask_o),
  .sfr_we_o(sfr_we_o), .sfr_re_o(sfr_re_o)
);

// File: tb/sim_idata_decoder.sv
module sim_idata_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] addr_i = '0;
  logic       indirect_i = 1'b0;
  logic [2:0] reg_idx_i = '0;
  logic [1:0] bank_sel_i = '0;
  logic [7:0] wdata_i = '0;
  logic       bit_wdata_i = 1'b0;
  logic [7:0] sfr_rdata_i = '0;
  logic [7:0] rdata_o, sp_o, sfr_addr_o, sfr_wdata_o, sfr_wmask_o;
  logic       bit_rdata_o, rvalid_o, sfr_we_o, sfr_re_o;

  always #5 clk_i = ~clk_i;

  idata_decoder u0 (.*);

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] ref_sp = 8'h07;
  // pending response from the previous step
  logic       p_valid = 0, p_sfr = 0, p_bit = 0;
  logic [7:0] p_data = '0, p_addr = '0;
  logic [2:0] p_idx = '0;
  string      p_req = "";

  function automatic logic [7:0] sfr_val(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [7:0] a, input logic ind,
                      input logic [2:0] ri, input logic [1:0] bk,
                      input logic [7:0] wd, input logic bwd);
    logic exp_re, exp_we, bw;
    logic [7:0] exp_addr, exp_wd, exp_mask, ra;
    @(negedge clk_i);
    sfr_rdata_i = p_sfr ? sfr_val(p_addr) : 8'hEE;
    op_i = op; addr_i = a; indirect_i = ind; reg_idx_i = ri;
    bank_sel_i = bk; wdata_i = wd; bit_wdata_i = bwd;
    #1;
    // previous response and pointer
    chk({p_req, " rvalid"}, rvalid_o, p_valid);
    if (p_valid) begin
      if (p_bit) chk({p_req, " bit"}, bit_rdata_o, p_sfr ? sfr_val(p_addr) >> p_idx & 1 : p_data >> p_idx & 1);
      else       chk({p_req, " data"}, rdata_o, p_sfr ? sfr_val(p_addr) : p_data);
    end
    chk("R10 sp", sp_o, ref_sp);
    // this request
    exp_re = 0; exp_we = 0; exp_addr = a; exp_wd = wd; exp_mask = 8'hFF;
    p_valid = 0; p_sfr = 0; p_bit = 0; p_idx = a[2:0];
    bw = (op == 4) ? 1'b1 : 1'b0;
    case (op)
      1, 2: begin
        p_req = (a >= 8'h80) ? (ind ? "R4" : "R3") : "R2";
        if (!ind && a >= 8'h80) begin
          if (op == 1) begin exp_re = 1; p_valid = 1; p_sfr = 1; p_addr = a; end
          else exp_we = 1;
        end else if (op == 1) begin p_valid = 1; p_data = ref_mem[a]; end
        else ref_mem[a] = wd;
      end
      3, 4: begin
        p_bit = (op == 3);
        if (a >= 8'h80) begin
          p_req = "R7";
          exp_addr = a & 8'hF8;
          exp_wd = {8{bwd}};
          exp_mask = 8'h01 << a[2:0];
          if (op == 3) begin exp_re = 1; p_valid = 1; p_sfr = 1; p_addr = exp_addr; end
          else exp_we = 1;
        end else begin
          p_req = "R6";
          ra = 8'h20 + (a >> 3);
          if (op == 3) begin p_valid = 1; p_data = ref_mem[ra]; end
          else ref_mem[ra][a[2:0]] = bwd;
        end
      end
      5: begin p_req = "R5"; p_valid = 1; p_data = ref_mem[bk * 8 + ri]; end
      6: begin p_req = "R5"; ref_mem[bk * 8 + ri] = wd; end
      7: begin p_req = "R8"; ref_sp = ref_sp + 8'd1; ref_mem[ref_sp] = wd; end
      8: begin p_req = "R9"; p_valid = 1; p_data = ref_mem[ref_sp]; ref_sp = ref_sp - 8'd1; end
      default: p_req = "R10";
    endcase
    chk({p_req, " sfr_re"}, sfr_re_o, exp_re);
    chk({p_req, " sfr_we"}, sfr_we_o, exp_we);
    if (exp_re || exp_we) chk({p_req, " sfr_addr"}, sfr_addr_o, exp_addr);
    if (exp_we) begin
      chk({p_req, " sfr_wdata"}, sfr_wdata_o, exp_wd);
      chk({p_req, " sfr_wmask"}, sfr_wmask_o, exp_mask);
    end
    if (bw) begin end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 sp reset", sp_o, 8'h07);
    chk("R1 rvalid reset", rvalid_o, 1'b0);
    chk("R1 strobes reset", {sfr_re_o, sfr_we_o}, 2'b00);
    rst_ni = 1'b1;
    // R2/R4: fill all RAM through the indirect path
    for (int i = 0; i < 256; i++) step(4'd2, 8'(i), 1'b1, 0, 0, 8'(i * 7 + 3), 0);
    for (int i = 0; i < 256; i += 17) step(4'd1, 8'(i), 1'b1, 0, 0, 0, 0);
    step(4'd1, 8'h45, 1'b0, 0, 0, 0, 0);
    step(4'd2, 8'h7F, 1'b0, 0, 0, 8'hC3, 0);
    step(4'd1, 8'h7F, 1'b1, 0, 0, 0, 0);
    // R3: direct upper goes to SFR, RAM untouched
    step(4'd2, 8'h90, 1'b0, 0, 0, 8'hA5, 0);
    step(4'd1, 8'hD0, 1'b0, 0, 0, 0, 0);
    step(4'd1, 8'h90, 1'b1, 0, 0, 0, 0);
    step(4'd1, 8'hFF, 1'b0, 0, 0, 0, 0);
    step(4'd1, 8'h80, 1'b1, 0, 0, 0, 0);
    // R5: registers in every bank
    for (int b = 0; b < 4; b++) begin
      step(4'd6, 0, 0, 3'(b + 3), 2'(b), 8'(8'h30 + b), 0);
      step(4'd5, 0, 0, 3'(b + 3), 2'(b), 0, 0);
      step(4'd1, 8'(b * 8 + b + 3), 1'b0, 0, 0, 0, 0);
    end
    // R6: RAM bits
    step(4'd2, 8'h21, 1'b0, 0, 0, 8'h00, 0);
    step(4'd4, 8'h0A, 1'b0, 0, 0, 0, 1'b1);
    step(4'd1, 8'h21, 1'b0, 0, 0, 0, 0);
    step(4'd3, 8'h0A, 1'b0, 0, 0, 0, 0);
    step(4'd3, 8'h0B, 1'b0, 0, 0, 0, 0);
    step(4'd4, 8'h7F, 1'b1, 0, 0, 0, 1'b0);
    step(4'd1, 8'h2F, 1'b0, 0, 0, 0, 0);
    // R7: SFR bits
    step(4'd4, 8'hE3, 1'b0, 0, 0, 0, 1'b1);
    step(4'd4, 8'h87, 1'b0, 0, 0, 0, 1'b0);
    step(4'd3, 8'hD5, 1'b0, 0, 0, 0, 0);
    step(4'd3, 8'hF9, 1'b0, 0, 0, 0, 0);
    // R8/R9: stack, including both wraps
    step(4'd7, 0, 0, 0, 0, 8'h11, 0);
    step(4'd7, 0, 0, 0, 0, 8'h22, 0);
    step(4'd8, 0, 0, 0, 0, 0, 0);
    step(4'd8, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 249; i++) step(4'd7, 0, 0, 0, 0, 8'(i ^ 8'h3C), 0);
    step(4'd1, 8'hF0, 1'b1, 0, 0, 0, 0);
    step(4'd8, 0, 0, 0, 0, 0, 0);
    step(4'd7, 0, 0, 0, 0, 8'h77, 0);
    step(4'd8, 0, 0, 0, 0, 0, 0);
    step(4'd8, 0, 0, 0, 0, 0, 0);
    // R10: idle and unused codes
    step(4'd0, 8'h90, 1'b0, 0, 0, 8'hFF, 1);
    for (int c = 9; c < 16; c++) step(4'(c), 8'h85, 1'b0, 0, 0, 8'hFF, 1);
    step(4'd1, 8'h85, 1'b1, 0, 0, 0, 0);
    step(4'd3, 8'h05, 1'b0, 0, 0, 0, 0);
    step(4'd0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule